// File: doc/BRIEF.md
# Vector Single-to-BFloat16 Narrowing Converter

This block takes a 128-bit vector holding four single-precision lanes and narrows each lane to a 16-bit BFloat16 value. It then writes the four results, packed into 64 bits, into one half of a 128-bit destination word. A part-select input picks the half. In the low form the packed result goes to the lower half and the upper half is zeroed. In the high form the packed result goes to the upper half and the lower half keeps the value of the current destination word. This lets two narrowing steps fill a whole register.

The rounding mode and a flush-to-zero control come from a floating-point control register outside the block. The datapath is combinational into one output register, so the result appears one clock after the inputs. No status or condition flags are produced.

Top module: `bf16_narrow_cvt`

## Requirements
- R1: While `rst_ni` is low, `dst_o` is all zeros.
- R2: `dst_o` reflects the inputs sampled at the previous rising edge of `clk_i`, which is one cycle of latency.
- R3: Source lane e is `src_i[32e+31:32e]`. Its BFloat16 result occupies 16-bit slot e of the 64-bit packed result, which is bits `16e+15:16e`.
- R4: With `high_i`=0, the packed result appears in `dst_o[63:0]` and `dst_o[127:64]` is zero.
- R5: With `high_i`=1, the packed result appears in `dst_o[127:64]` and `dst_o[63:0]` equals `dst_old_i[63:0]`.
- R6: With `rmode_i`=2'b00 (nearest, ties to even), a finite result is the upper 16 bits of the input, incremented when the discarded bits 15:0 exceed 0x8000, or equal 0x8000 while bit 16 is 1.
- R7: With `rmode_i`=2'b01 (toward +inf) or 2'b10 (toward -inf), a finite result is incremented in magnitude only when bits 15:0 are nonzero and the sign is positive (for 01) or negative (for 10).
- R8: With `rmode_i`=2'b11 (toward zero), a finite result is exactly the input's upper 16 bits.
- R9: An increment that carries out of the 7-bit fraction raises the exponent. Rounding the largest finite single up yields infinity (0x7F80 or 0xFF80).
- R10: Infinities and signed zeros convert to the same-signed BFloat16 infinity or zero in every rounding mode.
- R11: A NaN input yields a NaN with the sign kept, exponent all ones, quiet bit 6 set, and bits 5:0 taken from input bits 21:16.
- R12: With `ftz_i`=1, an input with exponent zero yields a zero of the same sign. With `ftz_i`=0 it is rounded like any other finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Four single-precision source lanes |
| dst_old_i | input | 128 | Current destination contents |
| high_i | input | 1 | 0: low form, 1: high form |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 +inf, 10 -inf, 11 zero |
| ftz_i | input | 1 | Flush subnormal inputs to signed zero |
| dst_o | output | 128 | New destination value |

## Verification
The bench targets exact halfway ties with even and odd kept bits. A design that rounds ties away from zero would return odd results for these. It also drives fractions of all ones near the top exponent, where a carry that fails to reach the exponent would produce a wrong value instead of infinity. Signalling NaNs with small payloads are included, because a design that only copies the top bits would let them become infinities. Negative values under the directed rounding modes catch a sign test that is reversed. Both part selections are run with random old contents, so a swapped half, or a lower half that is cleared instead of kept, shows up as a mismatch.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;
  localparam int unsigned F32_W  = 32;
  localparam int unsigned BF16_W = 16;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_POS     = 2'b01,
    RND_NEG     = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/bf16_lane_cvt.sv
module bf16_lane_cvt
  import bf16_cvt_pkg::*;
(
  input  logic [F32_W-1:0]  f32_i,
  input  rnd_mode_e         rmode_i,
  input  logic              ftz_i,
  output logic [BF16_W-1:0] bf16_o
);
  logic        sgn;
  logic [7:0]  expo;
  logic [22:0] frac;
  logic        kept_lsb, rnd_bit, sticky, inexact, bump;

  assign sgn      = f32_i[31];
  assign expo     = f32_i[30:23];
  assign frac     = f32_i[22:0];
  assign kept_lsb = f32_i[16];
  assign rnd_bit  = f32_i[15];
  assign sticky   = |f32_i[14:0];
  assign inexact  = rnd_bit | sticky;

  always_comb begin
    unique case (rmode_i)
      RND_NEAREST: bump = rnd_bit & (sticky | kept_lsb);
      RND_POS:     bump = inexact & ~sgn;
      RND_NEG:     bump = inexact & sgn;
      default:     bump = 1'b0;
    endcase
  end

  always_comb begin
    if (expo == 8'hFF) begin
      if (|frac) bf16_o = {sgn, 8'hFF, 1'b1, frac[21:16]};
      else       bf16_o = {sgn, 8'hFF, 7'h00};
    end else if (expo == 8'h00 && ftz_i) begin
      bf16_o = {sgn, 15'h0000};
    end else begin
      // magnitude below 0x7F80, so the add never wraps; carry reaches exponent
      bf16_o = {sgn, f32_i[30:16] + {14'd0, bump}};
    end
  end
endmodule

// File: rtl/bf16_half_place.sv
module bf16_half_place #(
  parameter int unsigned HALF_W = 64
) (
  input  logic [HALF_W-1:0]   res_i,
  input  logic [HALF_W-1:0]   old_lo_i,
  input  logic                high_i,
  output logic [2*HALF_W-1:0] vec_o
);
  always_comb begin
    if (high_i) vec_o = {res_i, old_lo_i};
    else        vec_o = {{HALF_W{1'b0}}, res_i};
  end
endmodule

// File: rtl/bf16_narrow_cvt.sv
module bf16_narrow_cvt
  import bf16_cvt_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned VEC_W    = NUM_LANES * F32_W,
  localparam int unsigned HALF_W   = NUM_LANES * BF16_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_old_i,
  input  logic             high_i,
  input  logic [1:0]       rmode_i,
  input  logic             ftz_i,
  output logic [VEC_W-1:0] dst_o
);
  logic [HALF_W-1:0] packed_res;
  logic [VEC_W-1:0]  next_dst;
  logic              unused_old_hi;

  assign unused_old_hi = ^dst_old_i[VEC_W-1:HALF_W];

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    bf16_lane_cvt lane_i (
      .f32_i   (src_i[ln*F32_W +: F32_W]),
      .rmode_i (rnd_mode_e'(rmode_i)),
      .ftz_i   (ftz_i),
      .bf16_o  (packed_res[ln*BF16_W +: BF16_W])
    );
  end

  bf16_half_place #(.HALF_W(HALF_W)) place_i (
    .res_i    (packed_res),
    .old_lo_i (dst_old_i[HALF_W-1:0]),
    .high_i   (high_i),
    .vec_o    (next_dst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dst_o <= '0;
    else         dst_o <= next_dst;
  end
endmodule

// File: rtl/bf16_narrow_cvt_chk.sv
module bf16_narrow_cvt_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] dst_old_i,
  input logic             high_i,
  input logic [1:0]       rmode_i,
  input logic [VEC_W-1:0] dst_o
);
  localparam int unsigned HW = VEC_W / 2;

  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_zero_chk: assert (dst_o == '0);

  // R4
  low_clears_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !high_i |=> dst_o[VEC_W-1:HW] == '0);

  // R5
  high_keeps_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_i |=> dst_o[HW-1:0] == $past(dst_old_i[HW-1:0]));

  // R8
  trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!high_i && rmode_i == 2'b11 && src_i[30:23] != 8'hFF && src_i[30:23] != 8'h00)
    |=> dst_o[15:0] == $past(src_i[31:16]));

  // R11
  nan_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!high_i && src_i[30:23] == 8'hFF && src_i[22:0] != '0)
    |=> dst_o[14:6] == 9'h1FF && dst_o[15] == $past(src_i[31]));

  // R10
  inf_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!high_i && src_i[30:0] == 31'h7F80_0000)
    |=> dst_o[14:0] == 15'h7F80);
endmodule

bind bf16_narrow_cvt bf16_narrow_cvt_chk #(.VEC_W(VEC_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .dst_old_i (dst_old_i),
  .high_i    (high_i),
  .rmode_i   (rmode_i),
  .dst_o     (dst_o)
);

// File: tb/bf16_narrow_cvt_tb_top.sv
module bf16_narrow_cvt_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] src_i = '0;
  logic [127:0] dst_old_i = '0;
  logic         high_i = 1'b0;
  logic [1:0]   rmode_i = 2'b00;
  logic         ftz_i = 1'b0;
  logic [127:0] dst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bf16_narrow_cvt dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .dst_old_i(dst_old_i),
    .high_i(high_i), .rmode_i(rmode_i), .ftz_i(ftz_i), .dst_o(dst_o)
  );

  function automatic logic [15:0] ref_bf(input logic [31:0] x, input logic [1:0] rm,
                                         input logic fz);
    logic [15:0] t;
    logic [15:0] r;
    logic up;
    if (x[30:23] == 8'hFF)
      return (x[22:0] != 0) ? {x[31], 8'hFF, 1'b1, x[21:16]} : {x[31], 15'h7F80};
    if (x[30:23] == 8'h00 && fz) return {x[31], 15'h0};
    t = x[31:16];
    r = x[15:0];
    case (rm)
      2'b00:   up = (r > 16'h8000) || (r == 16'h8000 && t[0]);
      2'b01:   up = (r != 0) && !x[31];
      2'b10:   up = (r != 0) && x[31];
      default: up = 1'b0;
    endcase
    return up ? {t[15], t[14:0] + 15'd1} : t;
  endfunction

  function automatic logic [127:0] ref_vec(input logic [127:0] s, input logic [127:0] o,
                                           input logic hi, input logic [1:0] rm,
                                           input logic fz);
    logic [63:0] res;
    for (int e = 0; e < 4; e++) res[16*e +: 16] = ref_bf(s[32*e +: 32], rm, fz);
    return hi ? {res, o[63:0]} : {64'd0, res};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] s, input logic [127:0] o,
                     input logic hi, input logic [1:0] rm, input logic fz);
    src_i = s; dst_old_i = o; high_i = hi; rmode_i = rm; ftz_i = fz;
    @(negedge clk_i);
    check(tag, dst_o, ref_vec(s, o, hi, rm, fz));
  endtask

  // one lane directed, others random; also checks the lane's slot explicitly
  task automatic lane1(input string tag, input logic [31:0] x, input logic hi,
                       input logic [1:0] rm, input logic fz, input logic [15:0] want);
    logic [127:0] s;
    logic [127:0] o;
    s = {$urandom, $urandom, x, $urandom};
    o = {$urandom, $urandom, $urandom, $urandom};
    run(tag, s, o, hi, rm, fz);
    n_run++;
    if (dst_o[(hi ? 64 : 0) + 16 +: 16] !== want) begin
      n_fail++;
      $display("FAIL %s lane actual=%h expected=%h", tag,
               dst_o[(hi ? 64 : 0) + 16 +: 16], want);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    src_i = {4{32'h3F80_0000}};
    dst_old_i = '1;
    @(negedge clk_i); @(negedge clk_i);
    check("R1 reset", dst_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: value appears one edge after drive
    check("R2 latency", dst_o, ref_vec(src_i, dst_old_i, 1'b0, 2'b00, 1'b0));

    lane1("R6 tie even",      32'h3F80_8000, 1'b0, 2'b00, 1'b0, 16'h3F80);
    lane1("R6 tie odd",       32'h3F81_8000, 1'b1, 2'b00, 1'b0, 16'h3F82);
    lane1("R6 above half",    32'h3F80_8001, 1'b0, 2'b00, 1'b0, 16'h3F81);
    lane1("R6 below half",    32'hBF80_7FFF, 1'b1, 2'b00, 1'b0, 16'hBF80);
    lane1("R7 pos up",        32'h3F80_0001, 1'b0, 2'b01, 1'b0, 16'h3F81);
    lane1("R7 pos neg trunc", 32'h8000_0001, 1'b0, 2'b01, 1'b0, 16'h8000);
    lane1("R7 neg up",        32'h8000_0001, 1'b1, 2'b10, 1'b0, 16'h8001);
    lane1("R7 neg pos trunc", 32'h3F80_FFFF, 1'b0, 2'b10, 1'b0, 16'h3F80);
    lane1("R8 zero trunc",    32'hC0FF_FFFF, 1'b1, 2'b11, 1'b0, 16'hC0FF);
    lane1("R9 exp carry",     32'h3FFF_FFFF, 1'b0, 2'b00, 1'b0, 16'h4000);
    lane1("R9 to inf",        32'h7F7F_FFFF, 1'b1, 2'b00, 1'b0, 16'h7F80);
    lane1("R9 neg to inf",    32'hFF7F_FFFF, 1'b0, 2'b10, 1'b0, 16'hFF80);
    lane1("R9 rz max",        32'h7F7F_FFFF, 1'b0, 2'b11, 1'b0, 16'h7F7F);
    lane1("R10 pos inf",      32'h7F80_0000, 1'b0, 2'b01, 1'b0, 16'h7F80);
    lane1("R10 neg inf",      32'hFF80_0000, 1'b1, 2'b00, 1'b0, 16'hFF80);
    lane1("R10 neg zero",     32'h8000_0000, 1'b0, 2'b10, 1'b0, 16'h8000);
    lane1("R11 snan small",   32'h7F80_0001, 1'b0, 2'b00, 1'b0, 16'h7FC0);
    lane1("R11 snan payload", 32'hFF81_0000, 1'b1, 2'b01, 1'b0, 16'hFFC1);
    lane1("R11 qnan",         32'h7FC5_0000, 1'b0, 2'b11, 1'b0, 16'h7FC5);
    lane1("R12 ftz",          32'h8040_0000, 1'b0, 2'b00, 1'b1, 16'h8000);
    lane1("R12 ftz up",       32'h0000_0001, 1'b1, 2'b01, 1'b1, 16'h0000);
    lane1("R12 sub round",    32'h0040_8000, 1'b0, 2'b00, 1'b0, 16'h0040);
    lane1("R12 sub up",       32'h0000_0001, 1'b0, 2'b01, 1'b0, 16'h0001);

    // R3 lane ordering with distinct exact lanes
    run("R3 lane order", 128'h4040_0000_4000_0000_3F80_0000_0000_0000,
        '1, 1'b0, 2'b11, 1'b0);
    check("R3 slots", dst_o, {64'd0, 64'h4040_4000_3F80_0000});
    // R4/R5 placement against all-ones old contents
    run("R5 keep low", {4{32'h3F80_0000}}, '1, 1'b1, 2'b00, 1'b0);
    check("R5 exact", dst_o, {{4{16'h3F80}}, 64'hFFFF_FFFF_FFFF_FFFF});
    run("R4 clear high", {4{32'h3F80_0000}}, '1, 1'b0, 2'b00, 1'b0);
    check("R4 exact", dst_o, {64'd0, {4{16'h3F80}}});

    for (int i = 0; i < 400; i++) begin
      logic [127:0] s;
      logic [127:0] o;
      s = {$urandom, $urandom, $urandom, $urandom};
      o = {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) s[63:32] = {s[63], 8'hFF, s[54:32]};
      if (i % 7 == 0) s[31:0] = {s[31], 8'h00, s[22:0]};
      if (i % 3 == 0) s[111:96] = 16'h8000;
      run("R3 R6 R7 R8 random", s, o, 1'(i % 2), 2'(i % 4), 1'((i / 4) % 2));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule